// File: doc/BRIEF.md
# Tachometer Timer Register Bank

This block is the bus-facing front of a two-channel fan tachometer timer. A synchronous slave bus reads and writes fifteen registers at fixed halfword-aligned offsets. The bank holds the prescaler, clock-select, mode, compare and input-select settings that the counting channels use. It also holds the counter and capture values. Each register accepts exactly one access width, and any access at a wrong width or at an unmapped offset is refused without side effects.

The two capture channels report six kinds of event as single-cycle strobes: capture, underflow and compare hit, for each of the two channels. Each strobe sets a sticky pending bit. Software clears pending bits by writing ones to a separate clear register, and it gates them onto a single level interrupt through an enable mask. The bank also decodes the mode and clock-select fields into a run qualifier and an edge polarity for each channel.

Top module: `tach_regbank`

## Requirements
- R1: The register map has fifteen registers. The halfword registers are CNT_A 0x00, CAPT_A 0x02, CAPT_B 0x04, CNT_B 0x06, CMP_A 0x14 and CMP_B 0x16, and they accept only busSize=1. The byte registers are PRESCALE 0x08, CLKSEL 0x0A, MODECTL 0x0C, PENDING 0x0E, PENDCLR 0x10, INTEN 0x12, CMPCFG 0x18, INSEL_A 0x1A and INSEL_B 0x1C, and they accept only busSize=0. A byte write stores busWdata[7:0], and a byte read returns the value zero-extended to 16 bits.
- R2: An access is rejected when its width is wrong for the register or when its offset is unmapped (odd, or above 0x1C). A rejected access raises busErr for exactly one cycle, returns zero read data and changes no register.
- R3: Read data and busErr appear on the cycle after the strobe. busRdata is zero in any cycle that does not follow an accepted read.
- R4: evtStrb bit positions are: channel A capture 0, channel B capture 1, channel A underflow 2, channel B underflow 3, channel A compare 4, channel B compare 5. A strobe sets the same bit of PENDING, and that bit stays set until it is cleared.
- R5: A byte write to PENDCLR clears every pending bit whose written bit is 1 and leaves the others. A read of PENDCLR is accepted and returns 0.
- R6: When an event strobe and a clear of the same bit happen in the same cycle, the bit ends up set.
- R7: INTEN uses the PENDING bit positions. irqOut is high exactly when some bit is both pending and enabled, and it follows the registered state with no further delay.
- R8: A byte write to PENDING is accepted but does not change the pending bits.
- R9: An active-low asynchronous reset clears PRESCALE through INSEL_B, including PENDING and INTEN, and holds irqOut low. It leaves CNT_A, CAPT_A, CAPT_B and CNT_B unchanged.
- R10: chanRunA is MODECTL bit 2 AND MODECTL bit 5 AND CLKSEL bit 0. chanRunB is MODECTL bit 2 AND MODECTL bit 6 AND CLKSEL bit 3. cfgEdgeA is MODECTL bit 3 and cfgEdgeB is MODECTL bit 4.
- R11: cfgPrsc, cfgCmpA, cfgCmpB and cfgCmpCfg carry PRESCALE, CMP_A, CMP_B and CMPCFG. cfgSelA and cfgSelB carry bit 0 of INSEL_A and INSEL_B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 16 | Write data |
| busSize | input | 1 | Access width: 0 byte, 1 halfword |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busRdata | output | 16 | Read data, one cycle after the strobe |
| busErr | output | 1 | Rejected access, one cycle after the strobe |
| evtStrb | input | 6 | Event strobes from the two capture channels |
| irqOut | output | 1 | Level interrupt |
| cfgPrsc | output | 8 | Prescaler setting |
| cfgCmpA | output | 16 | Channel A compare value |
| cfgCmpB | output | 16 | Channel B compare value |
| cfgCmpCfg | output | 8 | Compare configuration |
| cfgSelA | output | 1 | Channel A input select |
| cfgSelB | output | 1 | Channel B input select |
| cfgEdgeA | output | 1 | Channel A edge polarity |
| cfgEdgeB | output | 1 | Channel B edge polarity |
| chanRunA | output | 1 | Channel A run qualifier |
| chanRunB | output | 1 | Channel B run qualifier |

## Verification
Each bus access is driven on a falling edge and lasts one cycle. The rising edge that follows registers both the write and the read result, so busRdata and busErr are sampled on the next falling edge. Written settings reach the cfg and run outputs after that same rising edge. An event strobe sets its pending bit one rising edge later, and irqOut is checked on the next falling edge because it depends only on registered state. The reset checks sample just after the asynchronous assertion, and again after release through ordinary reads.

// File: rtl/tach_regbank_pkg.sv
`timescale 1ns/1ps
package tach_regbank_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int NUM_EVT = 6;

  // byte offsets seen by software
  localparam int OFF_CNT_A   = 'h00;
  localparam int OFF_CAPT_A  = 'h02;
  localparam int OFF_CAPT_B  = 'h04;
  localparam int OFF_CNT_B   = 'h06;
  localparam int OFF_PRSC    = 'h08;
  localparam int OFF_CLKSEL  = 'h0A;
  localparam int OFF_MODE    = 'h0C;
  localparam int OFF_PEND    = 'h0E;
  localparam int OFF_PCLR    = 'h10;
  localparam int OFF_INTEN   = 'h12;
  localparam int OFF_CMP_A   = 'h14;
  localparam int OFF_CMP_B   = 'h16;
  localparam int OFF_CMPCFG  = 'h18;
  localparam int OFF_INSEL_A = 'h1A;
  localparam int OFF_INSEL_B = 'h1C;

  // field positions the channels decode
  localparam int MC_CAPMODE = 2;
  localparam int MC_EDGE_A  = 3;
  localparam int MC_EDGE_B  = 4;
  localparam int MC_RUN_A   = 5;
  localparam int MC_RUN_B   = 6;
  localparam int CK_SEL_A   = 0;
  localparam int CK_SEL_B   = 3;

  typedef enum logic [3:0] {
    SEL_CNT_A, SEL_CAPT_A, SEL_CAPT_B, SEL_CNT_B, SEL_PRSC, SEL_CLKSEL,
    SEL_MODE, SEL_PEND, SEL_PCLR, SEL_INTEN, SEL_CMP_A, SEL_CMP_B,
    SEL_CMPCFG, SEL_INSEL_A, SEL_INSEL_B, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    logic    err;
    regSel_e sel;
  } busStrb_t;
endpackage

// File: rtl/tach_busctl.sv
`timescale 1ns/1ps
module tach_busctl
  import tach_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busSize,
  input  logic              busRd,
  input  logic              busWr,
  output busStrb_t          strb
);
  regSel_e sel;
  logic    wide;
  logic    legal;

  // one decode feeds both the width check and the register select
  always_comb begin
    sel  = SEL_NONE;
    wide = 1'b0;
    case (int'(busAddr))
      OFF_CNT_A:   begin sel = SEL_CNT_A;   wide = 1'b1; end
      OFF_CAPT_A:  begin sel = SEL_CAPT_A;  wide = 1'b1; end
      OFF_CAPT_B:  begin sel = SEL_CAPT_B;  wide = 1'b1; end
      OFF_CNT_B:   begin sel = SEL_CNT_B;   wide = 1'b1; end
      OFF_CMP_A:   begin sel = SEL_CMP_A;   wide = 1'b1; end
      OFF_CMP_B:   begin sel = SEL_CMP_B;   wide = 1'b1; end
      OFF_PRSC:    sel = SEL_PRSC;
      OFF_CLKSEL:  sel = SEL_CLKSEL;
      OFF_MODE:    sel = SEL_MODE;
      OFF_PEND:    sel = SEL_PEND;
      OFF_PCLR:    sel = SEL_PCLR;
      OFF_INTEN:   sel = SEL_INTEN;
      OFF_CMPCFG:  sel = SEL_CMPCFG;
      OFF_INSEL_A: sel = SEL_INSEL_A;
      OFF_INSEL_B: sel = SEL_INSEL_B;
      default:     sel = SEL_NONE;
    endcase
  end

  assign legal = (sel != SEL_NONE) && (busSize == wide);

  always_comb begin
    strb.wrEn = busWr & legal;
    strb.rdEn = busRd & legal;
    strb.err  = (busRd | busWr) & ~legal;
    strb.sel  = sel;
  end
endmodule

// File: rtl/tach_regfile.sv
`timescale 1ns/1ps
module tach_regfile
  import tach_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  busStrb_t           strb,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [NUM_EVT-1:0] evtStrb,
  output logic [WORD_W-1:0]  rdata,
  output logic               err,
  output logic [NUM_EVT-1:0] pend,
  output logic [NUM_EVT-1:0] ien,
  output logic [BYTE_W-1:0]  prsc,
  output logic [BYTE_W-1:0]  cmpCfg,
  output logic [WORD_W-1:0]  cmpA,
  output logic [WORD_W-1:0]  cmpB,
  output logic               selA,
  output logic               selB,
  output logic               edgeA,
  output logic               edgeB,
  output logic               runA,
  output logic               runB
);
  logic [WORD_W-1:0] cntA, captA, captB, cntB;
  logic [BYTE_W-1:0] clkSel, modeCtl, inSelA, inSelB;
  logic [WORD_W-1:0] rdVal;
  logic              clrHit;

  function automatic logic hit(input regSel_e s);
    return strb.wrEn && (strb.sel == s);
  endfunction

  // counter and capture values keep their contents across reset
  always_ff @(posedge clk) begin
    if (hit(SEL_CNT_A))  cntA  <= wdata;
    if (hit(SEL_CAPT_A)) captA <= wdata;
    if (hit(SEL_CAPT_B)) captB <= wdata;
    if (hit(SEL_CNT_B))  cntB  <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prsc    <= '0;
      clkSel  <= '0;
      modeCtl <= '0;
      ien     <= '0;
      cmpA    <= '0;
      cmpB    <= '0;
      cmpCfg  <= '0;
      inSelA  <= '0;
      inSelB  <= '0;
    end else begin
      if (hit(SEL_PRSC))    prsc    <= wdata[BYTE_W-1:0];
      if (hit(SEL_CLKSEL))  clkSel  <= wdata[BYTE_W-1:0];
      if (hit(SEL_MODE))    modeCtl <= wdata[BYTE_W-1:0];
      if (hit(SEL_INTEN))   ien     <= wdata[NUM_EVT-1:0];
      if (hit(SEL_CMP_A))   cmpA    <= wdata;
      if (hit(SEL_CMP_B))   cmpB    <= wdata;
      if (hit(SEL_CMPCFG))  cmpCfg  <= wdata[BYTE_W-1:0];
      if (hit(SEL_INSEL_A)) inSelA  <= wdata[BYTE_W-1:0];
      if (hit(SEL_INSEL_B)) inSelB  <= wdata[BYTE_W-1:0];
    end
  end

  assign clrHit = hit(SEL_PCLR);

  // one sticky flag per event source; a strobe outranks a clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pend[i] <= 1'b0;
      else       pend[i] <= evtStrb[i] | (pend[i] & ~(clrHit & wdata[i]));
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_CNT_A:   rdVal = cntA;
      SEL_CAPT_A:  rdVal = captA;
      SEL_CAPT_B:  rdVal = captB;
      SEL_CNT_B:   rdVal = cntB;
      SEL_PRSC:    rdVal = WORD_W'(prsc);
      SEL_CLKSEL:  rdVal = WORD_W'(clkSel);
      SEL_MODE:    rdVal = WORD_W'(modeCtl);
      SEL_PEND:    rdVal = WORD_W'(pend);
      SEL_INTEN:   rdVal = WORD_W'(ien);
      SEL_CMP_A:   rdVal = cmpA;
      SEL_CMP_B:   rdVal = cmpB;
      SEL_CMPCFG:  rdVal = WORD_W'(cmpCfg);
      SEL_INSEL_A: rdVal = WORD_W'(inSelA);
      SEL_INSEL_B: rdVal = WORD_W'(inSelB);
      default:     rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= strb.rdEn ? rdVal : '0;
      err   <= strb.err;
    end
  end

  assign selA  = inSelA[0];
  assign selB  = inSelB[0];
  assign edgeA = modeCtl[MC_EDGE_A];
  assign edgeB = modeCtl[MC_EDGE_B];
  assign runA  = modeCtl[MC_CAPMODE] & modeCtl[MC_RUN_A] & clkSel[CK_SEL_A];
  assign runB  = modeCtl[MC_CAPMODE] & modeCtl[MC_RUN_B] & clkSel[CK_SEL_B];
endmodule

// File: rtl/tach_regbank.sv
`timescale 1ns/1ps
module tach_regbank
  import tach_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busWdata,
  input  logic               busSize,
  input  logic               busRd,
  input  logic               busWr,
  output logic [WORD_W-1:0]  busRdata,
  output logic               busErr,
  input  logic [NUM_EVT-1:0] evtStrb,
  output logic               irqOut,
  output logic [BYTE_W-1:0]  cfgPrsc,
  output logic [WORD_W-1:0]  cfgCmpA,
  output logic [WORD_W-1:0]  cfgCmpB,
  output logic [BYTE_W-1:0]  cfgCmpCfg,
  output logic               cfgSelA,
  output logic               cfgSelB,
  output logic               cfgEdgeA,
  output logic               cfgEdgeB,
  output logic               chanRunA,
  output logic               chanRunB
);
  busStrb_t           strb;
  logic [NUM_EVT-1:0] pendW;
  logic [NUM_EVT-1:0] ienW;

  tach_busctl #(.ADDR_W(ADDR_W)) u_ctl (
    .busAddr (busAddr),
    .busSize (busSize),
    .busRd   (busRd),
    .busWr   (busWr),
    .strb    (strb)
  );

  tach_regfile u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .evtStrb (evtStrb),
    .rdata   (busRdata),
    .err     (busErr),
    .pend    (pendW),
    .ien     (ienW),
    .prsc    (cfgPrsc),
    .cmpCfg  (cfgCmpCfg),
    .cmpA    (cfgCmpA),
    .cmpB    (cfgCmpB),
    .selA    (cfgSelA),
    .selB    (cfgSelB),
    .edgeA   (cfgEdgeA),
    .edgeB   (cfgEdgeB),
    .runA    (chanRunA),
    .runB    (chanRunB)
  );

  assign irqOut = |(pendW & ienW);
endmodule

// File: rtl/tach_regbank_chk.sv
`timescale 1ns/1ps
module tach_regbank_chk
  import tach_regbank_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busRd,
  input logic               busErr,
  input logic [WORD_W-1:0]  busRdata,
  input logic [NUM_EVT-1:0] evtStrb,
  input logic [NUM_EVT-1:0] pend,
  input logic [NUM_EVT-1:0] ien,
  input logic               irqOut,
  input logic [BYTE_W-1:0]  cfgPrsc,
  input logic [WORD_W-1:0]  cfgCmpA,
  input logic [WORD_W-1:0]  cfgCmpB,
  input logic [BYTE_W-1:0]  cfgCmpCfg
);
  a_r2_err_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0));

  a_r2_err_no_cfg_change: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> ($stable(cfgPrsc) && $stable(cfgCmpA) && $stable(cfgCmpB) && $stable(cfgCmpCfg)));

  a_r3_idle_data_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (busRdata == '0));

  a_r4_no_spurious_pend: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evtStrb)) == '0));

  a_r6_event_sets_pend: assert property (@(posedge clk) disable iff (!rstN)
    (|evtStrb) |=> ((pend & $past(evtStrb)) == $past(evtStrb)));

  a_r7_irq_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ((($past(evtStrb) & ien) != '0) || ($past(ien) != ien)));
endmodule

bind tach_regbank tach_regbank_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busRd     (busRd),
  .busErr    (busErr),
  .busRdata  (busRdata),
  .evtStrb   (evtStrb),
  .pend      (pendW),
  .ien       (ienW),
  .irqOut    (irqOut),
  .cfgPrsc   (cfgPrsc),
  .cfgCmpA   (cfgCmpA),
  .cfgCmpB   (cfgCmpB),
  .cfgCmpCfg (cfgCmpCfg)
);

// File: tb/tb_tach_regbank.sv
`timescale 1ns/1ps
module tb_tach_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busSize = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busRdata;
  logic        busErr;
  logic [5:0]  evtStrb = '0;
  logic        irqOut;
  logic [7:0]  cfgPrsc, cfgCmpCfg;
  logic [15:0] cfgCmpA, cfgCmpB;
  logic        cfgSelA, cfgSelB, cfgEdgeA, cfgEdgeB, chanRunA, chanRunB;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic [15:0] rd;
  logic        er;

  always #2.5 clk = ~clk;

  tach_regbank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busSize(busSize), .busRd(busRd), .busWr(busWr), .busRdata(busRdata),
    .busErr(busErr), .evtStrb(evtStrb), .irqOut(irqOut), .cfgPrsc(cfgPrsc),
    .cfgCmpA(cfgCmpA), .cfgCmpB(cfgCmpB), .cfgCmpCfg(cfgCmpCfg),
    .cfgSelA(cfgSelA), .cfgSelB(cfgSelB), .cfgEdgeA(cfgEdgeA),
    .cfgEdgeB(cfgEdgeB), .chanRunA(chanRunA), .chanRunB(chanRunB)
  );

  task automatic expectEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one access: driven on a falling edge, results sampled on the next one
  task automatic busAcc(input logic wr, input int addr, input logic size, input logic [15:0] data);
    @(negedge clk);
    busAddr = addr[7:0]; busSize = size; busWdata = data; busWr = wr; busRd = ~wr;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    rd = busRdata; er = busErr;
  endtask

  task automatic wrOk(input string tag, input int addr, input logic size, input logic [15:0] data);
    busAcc(1'b1, addr, size, data);
    expectEq({tag, " write accepted"}, int'(er), 0);
  endtask

  task automatic rdExp(input string tag, input int addr, input logic size, input int exp);
    busAcc(1'b0, addr, size, 16'h0);
    expectEq({tag, " read error"}, int'(er), 0);
    expectEq({tag, " read data"}, int'(rd), exp);
  endtask

  task automatic pulse(input logic [5:0] mask);
    @(negedge clk); evtStrb = mask;
    @(negedge clk); evtStrb = '0;
  endtask

  task automatic t_reset_state;
    int offs[10] = '{'h08, 'h0A, 'h0C, 'h0E, 'h12, 'h14, 'h16, 'h18, 'h1A, 'h1C};
    bit wide[10] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0};
    expectEq("R9 irq low after reset", int'(irqOut), 0);
    expectEq("R9 run A low after reset", int'(chanRunA), 0);
    for (int i = 0; i < 10; i++) rdExp("R9 reset value", offs[i], wide[i], 0);
  endtask

  task automatic t_map;
    wrOk("R1 CNT_A", 'h00, 1'b1, 16'hA55A);
    wrOk("R1 CAPT_A", 'h02, 1'b1, 16'h1357);
    wrOk("R1 CAPT_B", 'h04, 1'b1, 16'h2468);
    wrOk("R1 CNT_B", 'h06, 1'b1, 16'hFEDC);
    wrOk("R1 CMP_A", 'h14, 1'b1, 16'h0F0F);
    wrOk("R1 CMP_B", 'h16, 1'b1, 16'h8001);
    wrOk("R1 PRESCALE", 'h08, 1'b0, 16'hAB5C);
    wrOk("R1 CMPCFG", 'h18, 1'b0, 16'h003A);
    wrOk("R1 INSEL_A", 'h1A, 1'b0, 16'h0001);
    wrOk("R1 INSEL_B", 'h1C, 1'b0, 16'h0002);
    wrOk("R1 INTEN", 'h12, 1'b0, 16'h002A);
    rdExp("R1 CNT_A", 'h00, 1'b1, 'hA55A);
    rdExp("R1 CAPT_A", 'h02, 1'b1, 'h1357);
    rdExp("R1 CAPT_B", 'h04, 1'b1, 'h2468);
    rdExp("R1 CNT_B", 'h06, 1'b1, 'hFEDC);
    rdExp("R1 CMP_B", 'h16, 1'b1, 'h8001);
    rdExp("R1 PRESCALE upper byte dropped", 'h08, 1'b0, 'h5C);
    rdExp("R1 INTEN", 'h12, 1'b0, 'h2A);
    rdExp("R1 INSEL_B", 'h1C, 1'b0, 'h02);
    wrOk("R1 INTEN off", 'h12, 1'b0, 16'h0000);
    expectEq("R11 cfgPrsc", int'(cfgPrsc), 'h5C);
    expectEq("R11 cfgCmpA", int'(cfgCmpA), 'h0F0F);
    expectEq("R11 cfgCmpB", int'(cfgCmpB), 'h8001);
    expectEq("R11 cfgCmpCfg", int'(cfgCmpCfg), 'h3A);
    expectEq("R11 cfgSelA", int'(cfgSelA), 1);
    expectEq("R11 cfgSelB", int'(cfgSelB), 0);
  endtask

  task automatic rejExp(input string tag, input logic wr, input int addr, input logic size);
    busAcc(wr, addr, size, 16'h1234);
    expectEq({tag, " error flag"}, int'(er), 1);
    expectEq({tag, " zero data"}, int'(rd), 0);
    @(negedge clk);
    expectEq({tag, " error lasts one cycle"}, int'(busErr), 0);
  endtask

  task automatic t_reject;
    rejExp("R2 halfword write to PRESCALE", 1'b1, 'h08, 1'b1);
    rejExp("R2 byte read of CNT_A", 1'b0, 'h00, 1'b0);
    rejExp("R2 byte write to CMP_A", 1'b1, 'h14, 1'b0);
    rejExp("R2 unmapped 0x1E", 1'b0, 'h1E, 1'b0);
    rejExp("R2 odd offset 0x03", 1'b0, 'h03, 1'b1);
    rejExp("R2 unmapped write 0x20", 1'b1, 'h20, 1'b0);
    rdExp("R2 PRESCALE kept", 'h08, 1'b0, 'h5C);
    rdExp("R2 CNT_A kept", 'h00, 1'b1, 'hA55A);
    expectEq("R2 cfgCmpA kept", int'(cfgCmpA), 'h0F0F);
  endtask

  task automatic t_idle_data;
    rdExp("R3 read before idle", 'h06, 1'b1, 'hFEDC);
    @(negedge clk);
    expectEq("R3 idle data zero", int'(busRdata), 0);
    wrOk("R3 write", 'h14, 1'b1, 16'h0F0F);
    expectEq("R3 data zero after write", int'(rd), 0);
  endtask

  task automatic t_events;
    for (int k = 0; k < 6; k++) begin
      pulse(6'(1 << k));
      expectEq("R4 irq stays low with mask clear", int'(irqOut), 0);
      rdExp("R4 pending position", 'h0E, 1'b0, 1 << k);
      wrOk("R4 clear", 'h10, 1'b0, 16'h003F);
      rdExp("R4 pending cleared", 'h0E, 1'b0, 0);
    end
  endtask

  task automatic t_clear;
    pulse(6'h3F);
    rdExp("R5 all pending", 'h0E, 1'b0, 'h3F);
    wrOk("R5 partial clear", 'h10, 1'b0, 16'h0005);
    rdExp("R5 unselected bits kept", 'h0E, 1'b0, 'h3A);
    rdExp("R5 clear register reads zero", 'h10, 1'b0, 0);
    wrOk("R5 rest clear", 'h10, 1'b0, 16'h003A);
    rdExp("R5 all cleared", 'h0E, 1'b0, 0);
  endtask

  task automatic t_race;
    pulse(6'h03);
    @(negedge clk);
    busAddr = 8'h10; busSize = 1'b0; busWdata = 16'h0003; busWr = 1'b1; evtStrb = 6'h01;
    @(negedge clk);
    busWr = 1'b0; evtStrb = '0;
    rdExp("R6 event beats clear", 'h0E, 1'b0, 'h01);
    wrOk("R6 cleanup", 'h10, 1'b0, 16'h003F);
  endtask

  task automatic t_irq;
    wrOk("R7 enable bit2", 'h12, 1'b0, 16'h0004);
    pulse(6'h08);
    expectEq("R7 masked event no irq", int'(irqOut), 0);
    pulse(6'h04);
    expectEq("R7 enabled event raises irq", int'(irqOut), 1);
    wrOk("R7 mask all", 'h12, 1'b0, 16'h0000);
    expectEq("R7 mask drops irq", int'(irqOut), 0);
    wrOk("R7 enable bit3", 'h12, 1'b0, 16'h0008);
    expectEq("R7 enabling pending raises irq", int'(irqOut), 1);
    wrOk("R7 clear", 'h10, 1'b0, 16'h000C);
    expectEq("R7 clear drops irq", int'(irqOut), 0);
  endtask

  task automatic t_pend_ro;
    wrOk("R8 write pending set", 'h0E, 1'b0, 16'h003F);
    rdExp("R8 pending unchanged", 'h0E, 1'b0, 0);
    expectEq("R8 irq unchanged", int'(irqOut), 0);
    pulse(6'h02);
    wrOk("R8 write pending zero", 'h0E, 1'b0, 16'h0000);
    rdExp("R8 pending kept", 'h0E, 1'b0, 'h02);
    wrOk("R8 cleanup", 'h10, 1'b0, 16'h003F);
  endtask

  task automatic t_run;
    wrOk("R10 mode", 'h0C, 1'b0, 16'h0064);
    wrOk("R10 clk both", 'h0A, 1'b0, 16'h0009);
    expectEq("R10 run A", int'(chanRunA), 1);
    expectEq("R10 run B", int'(chanRunB), 1);
    wrOk("R10 clk A only", 'h0A, 1'b0, 16'h0001);
    expectEq("R10 run A clk A", int'(chanRunA), 1);
    expectEq("R10 run B without clock", int'(chanRunB), 0);
    wrOk("R10 clk B only", 'h0A, 1'b0, 16'h0008);
    expectEq("R10 run A without clock", int'(chanRunA), 0);
    wrOk("R10 no capture mode", 'h0C, 1'b0, 16'h0060);
    wrOk("R10 clk both again", 'h0A, 1'b0, 16'h0009);
    expectEq("R10 run A needs mode", int'(chanRunA), 0);
    expectEq("R10 run B needs mode", int'(chanRunB), 0);
    wrOk("R10 edges no enables", 'h0C, 1'b0, 16'h001C);
    expectEq("R10 run A needs enable", int'(chanRunA), 0);
    expectEq("R10 edge A", int'(cfgEdgeA), 1);
    expectEq("R10 edge B", int'(cfgEdgeB), 1);
    wrOk("R10 edge A only", 'h0C, 1'b0, 16'h0008);
    expectEq("R10 edge A set", int'(cfgEdgeA), 1);
    expectEq("R10 edge B clear", int'(cfgEdgeB), 0);
  endtask

  task automatic t_reset_keep;
    wrOk("R9 CNT_A", 'h00, 1'b1, 16'h1111);
    wrOk("R9 CAPT_A", 'h02, 1'b1, 16'h2222);
    wrOk("R9 CAPT_B", 'h04, 1'b1, 16'h3333);
    wrOk("R9 CNT_B", 'h06, 1'b1, 16'h4444);
    wrOk("R9 PRESCALE", 'h08, 1'b0, 16'h0077);
    wrOk("R9 INTEN", 'h12, 1'b0, 16'h003F);
    pulse(6'h01);
    expectEq("R9 irq before reset", int'(irqOut), 1);
    @(negedge clk); rstN = 1'b0;
    #1;
    expectEq("R9 irq low in reset", int'(irqOut), 0);
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    rdExp("R9 CNT_A kept", 'h00, 1'b1, 'h1111);
    rdExp("R9 CAPT_A kept", 'h02, 1'b1, 'h2222);
    rdExp("R9 CAPT_B kept", 'h04, 1'b1, 'h3333);
    rdExp("R9 CNT_B kept", 'h06, 1'b1, 'h4444);
    rdExp("R9 PRESCALE cleared", 'h08, 1'b0, 0);
    rdExp("R9 pending cleared", 'h0E, 1'b0, 0);
    rdExp("R9 enable cleared", 'h12, 1'b0, 0);
    expectEq("R9 mode cleared run A", int'(chanRunA), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_map();
    t_reject();
    t_idle_data();
    t_events();
    t_clear();
    t_race();
    t_irq();
    t_pend_ro();
    t_run();
    t_reset_keep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R0 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule